// File: doc/BRIEF.md
# Programmable Video Source Select Controller

This block drives the select line of a two-way analog video switch. It runs on a free-running oscillator clock and chooses, every clock cycle, whether the switch passes source A or source B. Its inputs are the three digital outputs of an external sync separator: composite sync, the back-porch (burst) gate and the odd/even field level. It brings all three onto the clock with flop synchronizers. From them it derives a vertical-interval flag, a horizontal-sync flag, a line number within the field and a clock count within the line.

A three-bit policy code selects how the source is chosen. The source can follow the field, alternate after a programmed number of even fields, or alternate after a programmed number of seconds. It can also split the picture at a line, pick a band of lines, pick the part of each line after a programmed clock count, or pick a rectangle that combines the band and the clock count. The policy code and its limits are taken up only when a new vertical interval begins, so a change never tears a field. A lamp output changes state once per field as a visible heartbeat. The decoded timing is brought out as debug taps.

Top module: `vsel_ctrl`

## Requirements
- R1: After reset `sel_o`, `led_o`, `vsync_o`, `hsync_o` and `line_o` are all 0; `sel_o` = 1 means source A and 0 means source B.
- R2: `vsync_o` takes the synchronized composite sync level at each falling edge of the gate: it sets when sync is still asserted then and clears when it is not.
- R3: `hsync_o` sets on a rising edge of sync while `vsync_o` is 0, never sets while `vsync_o` is 1, and clears at the next falling edge of the gate.
- R4: `line_o` is held at 0 while `vsync_o` is 1 and otherwise steps by one on each horizontal sync (saturating), so the k-th line after the vertical interval (counting from 0) reads k.
- R5: `pix_o` restarts at 0 on each horizontal sync and then advances by one every clock.
- R6: Policy code 0 (and reserved code 7): `sel_o` follows the field level, 1 in the odd field (`field_i` = 1) and 0 in the even field.
- R7: Policy code 1: `sel_o` starts at 0 and inverts at every `frame_lim_i`-th start of an even field (falling edge of the field level); a limit of 0 acts as 1.
- R8: Policy code 2: `sel_o` starts at 0 and inverts every `secs_lim_i` × `CLK_HZ` clock cycles; a limit of 0 acts as 1.
- R9: Policy code 3: `sel_o` is 1 for lines below `HALF_LINE` (default 131) and 0 from that line on.
- R10: Policy code 4: `sel_o` is 1 only for lines strictly above `LWIN_LO` (default 127) and strictly below `LWIN_HI` (default 192).
- R11: Policy code 5: `sel_o` is 1 when `pix_o` is at least `pix_lim_i` and 0 before it.
- R12: Policy code 6: `sel_o` is 1 only where both the R10 line band and the R11 clock condition hold.
- R13: `mode_i`, `frame_lim_i`, `secs_lim_i` and `pix_lim_i` are taken up only at the rising edge of `vsync_o`; changes at other times have no effect on the current field.
- R14: `led_o` inverts at each rising edge of `vsync_o` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| sync_i | input | 1 | Composite sync from the separator (asynchronous) |
| gate_i | input | 1 | Back-porch / burst gate from the separator (asynchronous) |
| field_i | input | 1 | Odd/even field level (asynchronous), 1 = odd |
| mode_i | input | 3 | Policy code, see R6 to R12 |
| frame_lim_i | input | FRM_W | Even fields per toggle for policy 1 |
| secs_lim_i | input | SEC_W | Seconds per toggle for policy 2 |
| pix_lim_i | input | PIX_W | Clock count threshold for policies 5 and 6 |
| sel_o | output | 1 | Switch select, 1 = source A |
| led_o | output | 1 | Per-field lamp drive |
| vsync_o | output | 1 | Vertical interval flag (debug) |
| hsync_o | output | 1 | Horizontal sync flag (debug) |
| line_o | output | LINE_W | Line within field (debug) |
| pix_o | output | PIX_W | Clocks since horizontal sync (debug) |

## Verification
The bench builds synthetic fields from long-sync vertical lines and short-sync active lines. It checks the line at which the count leaves zero after the vertical interval: a design that counted the first sync of the interval, or the line that ends it, would put every window one line off. The band edges at lines 127, 128, 191 and 192 and the split at 130/131 are sampled directly, which catches inclusive comparisons. A policy change written in mid-field must leave that field untouched, which a design that loaded the register at once would tear. The even-field and seconds counters are checked for their exact period, so a counter that toggled one event early or late shows up as a wrong sequence or interval.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

   typedef enum logic [2:0] {
      M_FIELD  = 3'd0,
      M_FRAMES = 3'd1,
      M_TIMED  = 3'd2,
      M_HALF   = 3'd3,
      M_LWIN   = 3'd4,
      M_PWIN   = 3'd5,
      M_RECT   = 3'd6,
      M_RSVD   = 3'd7
   } mode_e;

endpackage

// File: rtl/vsel_insync.sv
module vsel_insync #(
   parameter int STAGES  = 2,
   parameter bit ACT_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic prev
);

   logic              din_act;
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (ACT_LOW) begin : g_inv
         assign din_act = ~din;
      end else begin : g_pass
         assign din_act = din;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din_act};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl  = chain_q[STAGES-1];
   assign prev = prev_q;

endmodule

// File: rtl/vsel_timing.sv
module vsel_timing #(
   parameter int LINE_W = 10,
   parameter int PIX_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_lvl,
   input  logic              sync_prev,
   input  logic              gate_lvl,
   input  logic              gate_prev,
   output logic              vsync_q,
   output logic              vs_rise,
   output logic              hsync_q,
   output logic [LINE_W-1:0] line_q,
   output logic [PIX_W-1:0]  pix_q
);

   localparam logic [LINE_W-1:0] LINE_MAX = '1;
   localparam logic [PIX_W-1:0]  PIX_MAX  = '1;

   logic gate_fall;
   logic sync_rise;
   logic hs_set;

   assign gate_fall = gate_prev & ~gate_lvl;
   assign sync_rise = sync_lvl & ~sync_prev;
   assign hs_set    = sync_rise & ~vsync_q;
   assign vs_rise   = gate_fall & sync_lvl & ~vsync_q;

   // vertical interval: sync level sampled at the end of the gate
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsync_q <= 1'b0;
      end else if (gate_fall) begin
         vsync_q <= sync_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_q <= 1'b0;
      end else if (gate_fall) begin
         hsync_q <= 1'b0;
      end else if (hs_set) begin
         hsync_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
      end else if (vsync_q) begin
         line_q <= '0;
      end else if (hs_set && line_q != LINE_MAX) begin
         line_q <= line_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q <= '0;
      end else if (hs_set) begin
         pix_q <= '0;
      end else if (pix_q != PIX_MAX) begin
         pix_q <= pix_q + 1'b1;
      end
   end

endmodule

// File: rtl/vsel_policy.sv
module vsel_policy
   import vsel_pkg::*;
#(
   parameter int LINE_W    = 10,
   parameter int PIX_W     = 11,
   parameter int FRM_W     = 8,
   parameter int SEC_W     = 6,
   parameter int CLK_HZ    = 27_000_000,
   parameter int HALF_LINE = 131,
   parameter int LWIN_LO   = 127,
   parameter int LWIN_HI   = 192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs_rise,
   input  logic              fld_lvl,
   input  logic              fld_prev,
   input  logic [LINE_W-1:0] line,
   input  logic [PIX_W-1:0]  pix,
   input  logic [2:0]        mode_i,
   input  logic [FRM_W-1:0]  frame_lim_i,
   input  logic [SEC_W-1:0]  secs_lim_i,
   input  logic [PIX_W-1:0]  pix_lim_i,
   output logic              sel_q,
   output logic [2:0]        mode_q
);

   localparam int                PRE_W    = $clog2(CLK_HZ);
   localparam logic [PRE_W-1:0]  PRE_MAX  = PRE_W'(CLK_HZ - 1);
   localparam logic [LINE_W-1:0] HALF_V   = LINE_W'(HALF_LINE);
   localparam logic [LINE_W-1:0] LO_V     = LINE_W'(LWIN_LO);
   localparam logic [LINE_W-1:0] HI_V     = LINE_W'(LWIN_HI);

   mode_e            act_mode;
   logic [FRM_W-1:0] act_frm;
   logic [SEC_W-1:0] act_sec;
   logic [PIX_W-1:0] act_pix;

   // configuration is taken up only when a vertical interval starts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_mode <= M_FIELD;
         act_frm  <= '0;
         act_sec  <= '0;
         act_pix  <= '0;
      end else if (vs_rise) begin
         act_mode <= mode_e'(mode_i);
         act_frm  <= frame_lim_i;
         act_sec  <= secs_lim_i;
         act_pix  <= pix_lim_i;
      end
   end

   // even-field counter
   logic             even_start;
   logic [FRM_W:0]   frm_eff;
   logic [FRM_W-1:0] frm_cnt;
   logic             frm_tog;

   assign even_start = fld_prev & ~fld_lvl;
   assign frm_eff    = (act_frm == '0) ? (FRM_W+1)'(1) : {1'b0, act_frm};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_cnt <= '0;
         frm_tog <= 1'b0;
      end else if (act_mode != M_FRAMES) begin
         frm_cnt <= '0;
         frm_tog <= 1'b0;
      end else if (even_start) begin
         if (({1'b0, frm_cnt} + (FRM_W+1)'(1)) >= frm_eff) begin
            frm_cnt <= '0;
            frm_tog <= ~frm_tog;
         end else begin
            frm_cnt <= frm_cnt + 1'b1;
         end
      end
   end

   // seconds timer: prescaler then seconds counter
   logic [PRE_W-1:0] pre_cnt;
   logic [SEC_W-1:0] sec_cnt;
   logic [SEC_W:0]   sec_eff;
   logic             tim_tog;

   assign sec_eff = (act_sec == '0) ? (SEC_W+1)'(1) : {1'b0, act_sec};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         sec_cnt <= '0;
         tim_tog <= 1'b0;
      end else if (act_mode != M_TIMED) begin
         pre_cnt <= '0;
         sec_cnt <= '0;
         tim_tog <= 1'b0;
      end else if (pre_cnt == PRE_MAX) begin
         pre_cnt <= '0;
         if (({1'b0, sec_cnt} + (SEC_W+1)'(1)) >= sec_eff) begin
            sec_cnt <= '0;
            tim_tog <= ~tim_tog;
         end else begin
            sec_cnt <= sec_cnt + 1'b1;
         end
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   // spatial windows
   logic in_half;
   logic in_lwin;
   logic in_pix;
   logic sel_d;

   assign in_half = (line < HALF_V);
   assign in_lwin = (line > LO_V) && (line < HI_V);
   assign in_pix  = (pix >= act_pix);

   always_comb begin
      unique case (act_mode)
         M_FRAMES: sel_d = frm_tog;
         M_TIMED:  sel_d = tim_tog;
         M_HALF:   sel_d = in_half;
         M_LWIN:   sel_d = in_lwin;
         M_PWIN:   sel_d = in_pix;
         M_RECT:   sel_d = in_lwin & in_pix;
         default:  sel_d = fld_lvl;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
      end else begin
         sel_q <= sel_d;
      end
   end

   assign mode_q = act_mode;

endmodule

// File: rtl/vsel_ctrl.sv
module vsel_ctrl #(
   parameter int SYNC_STAGES  = 2,
   parameter bit SYNC_ACT_LOW = 1'b0,
   parameter bit GATE_ACT_LOW = 1'b0,
   parameter int LINE_W       = 10,
   parameter int PIX_W        = 11,
   parameter int FRM_W        = 8,
   parameter int SEC_W        = 6,
   parameter int CLK_HZ       = 27_000_000,
   parameter int HALF_LINE    = 131,
   parameter int LWIN_LO      = 127,
   parameter int LWIN_HI      = 192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_i,
   input  logic              gate_i,
   input  logic              field_i,
   input  logic [2:0]        mode_i,
   input  logic [FRM_W-1:0]  frame_lim_i,
   input  logic [SEC_W-1:0]  secs_lim_i,
   input  logic [PIX_W-1:0]  pix_lim_i,
   output logic              sel_o,
   output logic              led_o,
   output logic              vsync_o,
   output logic              hsync_o,
   output logic [LINE_W-1:0] line_o,
   output logic [PIX_W-1:0]  pix_o
);

   // elaboration-time parameter checks
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         initial $fatal(1, "vsel_ctrl: SYNC_STAGES must be at least 2");
      end
      if (CLK_HZ < 2) begin : g_bad_clk
         initial $fatal(1, "vsel_ctrl: CLK_HZ must be at least 2");
      end
      if (LWIN_HI <= LWIN_LO + 1) begin : g_bad_win
         initial $fatal(1, "vsel_ctrl: line band is empty");
      end
      if (LWIN_HI >= (1 << LINE_W) || HALF_LINE >= (1 << LINE_W)) begin : g_bad_line
         initial $fatal(1, "vsel_ctrl: line thresholds exceed LINE_W");
      end
   endgenerate

   logic sync_lvl, sync_prev;
   logic gate_lvl, gate_prev;
   logic fld_lvl,  fld_prev;

   vsel_insync #(.STAGES(SYNC_STAGES), .ACT_LOW(SYNC_ACT_LOW)) u_sync_sync (
      .clk(clk), .rst_n(rst_n), .din(sync_i), .lvl(sync_lvl), .prev(sync_prev));

   vsel_insync #(.STAGES(SYNC_STAGES), .ACT_LOW(GATE_ACT_LOW)) u_sync_gate (
      .clk(clk), .rst_n(rst_n), .din(gate_i), .lvl(gate_lvl), .prev(gate_prev));

   vsel_insync #(.STAGES(SYNC_STAGES), .ACT_LOW(1'b0)) u_sync_field (
      .clk(clk), .rst_n(rst_n), .din(field_i), .lvl(fld_lvl), .prev(fld_prev));

   logic              vsync_q;
   logic              vs_rise;
   logic              hsync_q;
   logic [LINE_W-1:0] line_q;
   logic [PIX_W-1:0]  pix_q;

   vsel_timing #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_lvl  (sync_lvl),
      .sync_prev (sync_prev),
      .gate_lvl  (gate_lvl),
      .gate_prev (gate_prev),
      .vsync_q   (vsync_q),
      .vs_rise   (vs_rise),
      .hsync_q   (hsync_q),
      .line_q    (line_q),
      .pix_q     (pix_q)
   );

   logic       sel_q;
   logic [2:0] cur_mode;

   vsel_policy #(
      .LINE_W(LINE_W), .PIX_W(PIX_W), .FRM_W(FRM_W), .SEC_W(SEC_W),
      .CLK_HZ(CLK_HZ), .HALF_LINE(HALF_LINE), .LWIN_LO(LWIN_LO), .LWIN_HI(LWIN_HI)
   ) u_policy (
      .clk         (clk),
      .rst_n       (rst_n),
      .vs_rise     (vs_rise),
      .fld_lvl     (fld_lvl),
      .fld_prev    (fld_prev),
      .line        (line_q),
      .pix         (pix_q),
      .mode_i      (mode_i),
      .frame_lim_i (frame_lim_i),
      .secs_lim_i  (secs_lim_i),
      .pix_lim_i   (pix_lim_i),
      .sel_q       (sel_q),
      .mode_q      (cur_mode)
   );

   logic led_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q <= 1'b0;
      end else if (vs_rise) begin
         led_q <= ~led_q;
      end
   end

   assign sel_o   = sel_q;
   assign led_o   = led_q;
   assign vsync_o = vsync_q;
   assign hsync_o = hsync_q;
   assign line_o  = line_q;
   assign pix_o   = pix_q;

endmodule

// File: rtl/vsel_ctrl_chk.sv
module vsel_ctrl_chk #(
   parameter int LINE_W  = 10,
   parameter int PIX_W   = 11,
   parameter int LWIN_LO = 127,
   parameter int LWIN_HI = 192
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_o,
   input logic              led_o,
   input logic              vsync_o,
   input logic              hsync_o,
   input logic [LINE_W-1:0] line_o,
   input logic [PIX_W-1:0]  pix_o,
   input logic [2:0]        cur_mode,
   input logic              fld_lvl
);

   localparam logic [LINE_W-1:0] LO_V = LINE_W'(LWIN_LO);
   localparam logic [LINE_W-1:0] HI_V = LINE_W'(LWIN_HI);

   AST_NO_HS_IN_VS: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_o |=> !$rose(hsync_o)); // R3

   AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_o |=> (line_o == '0)); // R4

   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_o |=> (line_o == $past(line_o)) || (line_o == LINE_W'($past(line_o) + 1'b1))); // R4

   AST_PIX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync_o) |-> (pix_o == '0)); // R5

   AST_FIELD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd0) |=> (sel_o == $past(fld_lvl))); // R6

   AST_LINE_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd4) |=> (sel_o == (($past(line_o) > LO_V) && ($past(line_o) < HI_V)))); // R10

   AST_CFG_AT_VS: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(vsync_o) |-> $stable(cur_mode)); // R13

   AST_LED_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync_o) |-> !$stable(led_o)); // R14

   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(vsync_o) |-> $stable(led_o)); // R14

endmodule

bind vsel_ctrl vsel_ctrl_chk #(
   .LINE_W(LINE_W), .PIX_W(PIX_W), .LWIN_LO(LWIN_LO), .LWIN_HI(LWIN_HI)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_o    (sel_o),
   .led_o    (led_o),
   .vsync_o  (vsync_o),
   .hsync_o  (hsync_o),
   .line_o   (line_o),
   .pix_o    (pix_o),
   .cur_mode (cur_mode),
   .fld_lvl  (fld_lvl)
);

// File: tb/vsel_ctrl_tb.sv
`timescale 1ns/1ps
module vsel_ctrl_tb;

   localparam int LINE_W = 10;
   localparam int PIX_W  = 11;
   localparam int FRM_W  = 8;
   localparam int SEC_W  = 6;
   localparam int HZ     = 50;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sync_i = 1'b0;
   logic              gate_i = 1'b0;
   logic              field_i = 1'b0;
   logic [2:0]        mode_i = 3'd0;
   logic [FRM_W-1:0]  frame_lim_i = '0;
   logic [SEC_W-1:0]  secs_lim_i = '0;
   logic [PIX_W-1:0]  pix_lim_i = '0;
   logic              sel_o;
   logic              led_o;
   logic              vsync_o;
   logic              hsync_o;
   logic [LINE_W-1:0] line_o;
   logic [PIX_W-1:0]  pix_o;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;
   int  e_sel;
   int  e_hs;

   always #2 clk = ~clk;

   vsel_ctrl #(.CLK_HZ(HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .gate_i(gate_i), .field_i(field_i),
      .mode_i(mode_i), .frame_lim_i(frame_lim_i), .secs_lim_i(secs_lim_i),
      .pix_lim_i(pix_lim_i), .sel_o(sel_o), .led_o(led_o), .vsync_o(vsync_o),
      .hsync_o(hsync_o), .line_o(line_o), .pix_o(pix_o));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // vertical-interval line: sync still high when the gate falls
   task automatic vline();
      sync_i = 1'b1; tick(4);
      gate_i = 1'b1; tick(3);
      gate_i = 1'b0; tick(3);
      sync_i = 1'b0; tick(17);
   endtask

   // active line: short sync, gate, picture; early samples taken mid-sync
   task automatic hline();
      sync_i = 1'b1; tick(4);
      e_sel = sel_o;
      e_hs  = hsync_o;
      sync_i = 1'b0; gate_i = 1'b1; tick(3);
      gate_i = 1'b0; tick(20);
   endtask

   function automatic int exp_end(input int m, input int k, input bit fld);
      case (m)
         3:       return (k < 131) ? 1 : 0;
         4, 6:    return (k > 127 && k < 192) ? 1 : 0;
         5:       return 1;
         default: return fld;
      endcase
   endfunction

   function automatic string tag_of(input int m);
      case (m)
         3:       return "R9";
         4:       return "R10";
         5:       return "R11";
         6:       return "R12";
         default: return "R6";
      endcase
   endfunction

   task automatic run_field(input bit fld, input int n, input int chk_mode,
                            input int chg_at, input int chg_mode);
      int led0;
      field_i = fld;
      led0 = led_o;
      vline(); vline(); vline();
      chk("R14 lamp flips per field", led_o, led0 ^ 1);
      for (int k = 0; k < n; k++) begin
         if (k == chg_at) mode_i = 3'(chg_mode);
         hline();
         if (chk_mode >= 0) begin
            if (chg_at >= 0 && k >= chg_at)
               chk("R13 mid-field change ignored", sel_o, exp_end(chk_mode, k, fld));
            else
               chk(tag_of(chk_mode), sel_o, exp_end(chk_mode, k, fld));
            if ((chk_mode == 5 || chk_mode == 6) && k >= 1)
               chk({tag_of(chk_mode), " before threshold"}, e_sel, 0);
         end
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; tick(4);
      rst_n = 1'b1; tick(2);
      chk("R1 sel", sel_o, 0);
      chk("R1 led", led_o, 0);
      chk("R1 vsync", vsync_o, 0);
      chk("R1 hsync", hsync_o, 0);
      chk("R1 line", line_o, 0);
   endtask

   task automatic t_sync_decode();
      int led0;
      mode_i = 3'd0;
      field_i = 1'b1;
      led0 = led_o;
      vline();
      chk("R2 vsync set by sync at gate end", vsync_o, 1);
      chk("R3 hsync cleared at gate end", hsync_o, 0);
      chk("R14 lamp", led_o, led0 ^ 1);
      vline();
      chk("R3 no hsync in vertical interval", hsync_o, 0);
      vline();
      chk("R4 line held in vertical interval", line_o, 0);
      for (int k = 0; k < 6; k++) begin
         hline();
         chk("R3 hsync during sync", e_hs, (k >= 1) ? 1 : 0);
         chk("R3 hsync cleared", hsync_o, 0);
         chk("R2 vsync cleared", vsync_o, 0);
         chk("R4 line number", line_o, k);
         if (k >= 1) chk("R5 clocks since sync", pix_o, 24);
      end
   endtask

   task automatic t_field_mode();
      mode_i = 3'd0;
      run_field(1'b0, 12, 0, -1, 0);
      run_field(1'b1, 12, 0, -1, 0);
      mode_i = 3'd7;
      run_field(1'b0, 8, 0, -1, 0);
   endtask

   task automatic t_cfg_hold();
      mode_i = 3'd0;
      run_field(1'b1, 210, 0, 50, 4);
      run_field(1'b0, 210, 4, -1, 0);
   endtask

   task automatic t_half();
      mode_i = 3'd3;
      run_field(1'b1, 210, 3, -1, 0);
   endtask

   task automatic t_pix();
      mode_i = 3'd5;
      pix_lim_i = 11'd14;
      run_field(1'b0, 6, 5, -1, 0);
   endtask

   task automatic t_rect();
      mode_i = 3'd6;
      pix_lim_i = 11'd14;
      run_field(1'b0, 200, 6, -1, 0);
   endtask

   task automatic t_frames();
      int exp_seq [8] = '{0, 0, 0, 1, 1, 1, 1, 0};
      mode_i = 3'd1;
      frame_lim_i = 8'd2;
      for (int f = 0; f < 8; f++) begin
         run_field((f % 2 == 0) ? 1'b1 : 1'b0, 5, -1, -1, 0);
         chk("R7 even-field toggle", sel_o, exp_seq[f]);
      end
   endtask

   task automatic t_timed();
      int t;
      logic s0;
      mode_i = 3'd2;
      secs_lim_i = 6'd3;
      run_field(1'b1, 2, -1, -1, 0);
      s0 = sel_o; t = 0;
      while (sel_o == s0 && t < 1000) begin tick(1); t++; end
      for (int r = 0; r < 2; r++) begin
         s0 = sel_o; t = 0;
         while (sel_o == s0 && t < 1000) begin tick(1); t++; end
         chk("R8 timed interval", t, 3 * HZ);
      end
   endtask

   initial begin
      t_reset();
      t_sync_decode();
      t_field_mode();
      t_cfg_hold();
      t_half();
      t_pix();
      t_rect();
      t_frames();
      t_timed();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule